// File: doc/BRIEF.md
# Next Program Counter and Call Link Unit

This block sits in the fetch stage of a 32-bit single-cycle load/store core. It takes the address of the current instruction, the instruction word and the two source operand values already read from the register file. From these it decides where the next instruction comes from, and whether the current instruction writes a return address into the register file. The unit is purely combinational, so the core registers `next_pc_o` into its program counter on the same edge at which it commits the link write.

The unit chooses among four next-address sources: the sequential address, a PC-relative branch target, a 256 MB region target built from a 26-bit field, and a target read from a register. There are no delay slots. A transfer takes effect at the very next instruction, and every return address is the current address plus four. Addition wraps modulo 2^32.

Top module: `flow_next_pc`

## Requirements
- R1: Any instruction that is not a branch or jump (opcode bits [31:26] other than 000010..000111 and other than 000000 with function bits [5:0] of 001000 or 001001) gives `next_pc_o` = PC+4, `taken_o` = 0 and `link_we_o` = 0.
- R2: A branch target is PC+4 plus the sign-extended immediate in bits [15:0] shifted left by two. A branch that is not taken gives PC+4.
- R3: Opcode 000100 is taken when the rs value equals the rt value. Opcode 000101 is taken when they differ. The rs field is bits [25:21] and the rt field is bits [20:16].
- R4: Opcode 000110 is taken when rs, read as a signed number, is at most zero. Opcode 000111 is taken when rs is strictly positive. The rt value has no effect on either.
- R5: Opcode 000010 jumps to {PC+4 bits [31:28], instruction bits [25:0], 00} and writes no link.
- R6: Opcode 000011 jumps to the same region target and writes the link with destination 31.
- R7: Opcode 000000 with function 001000 jumps to the rs value and writes no link.
- R8: Opcode 000000 with function 001001 jumps to the rs value and writes the link to the rd field (bits [15:11]), or to 31 when rd is 0. A link write is never raised with destination 0.
- R9: Opcode 000000 with any other function code is not a transfer.
- R10: `taken_o` is 1 for every jump and for every branch whose condition holds, and 0 otherwise. `link_data_o` always equals PC+4, and `link_idx_o` is 0 whenever `link_we_o` is 0.
- R11: PC+4, branch targets and the upper bits of region targets wrap modulo 2^32, so the instruction at 0xFFFFFFFC takes its region bits from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Address of the current instruction |
| instr_i | input | 32 | Current instruction word |
| rs_val_i | input | 32 | Value of the register named by bits [25:21] |
| rt_val_i | input | 32 | Value of the register named by bits [20:16] |
| next_pc_o | output | 32 | Address of the next instruction |
| taken_o | output | 1 | A control transfer is in effect |
| link_we_o | output | 1 | Write the return address into the register file |
| link_idx_o | output | 5 | Destination register of the link write |
| link_data_o | output | 32 | Return address (PC+4) |

## Verification
Immediate assertions are evaluated whenever any input changes. They check that the decoder never selects more than one transfer source, that a comparison which is not selected never reports a hit, that a non-transfer always yields PC+4, that a region target keeps the upper bits of PC+4 and zeroes its low two bits, and that a link write is raised only on a transfer and never to register 0. The assertions cannot show that a target value is correct. Only the directed scenarios can show that: the exact branch arithmetic at the extreme offsets, the signed treatment of zero and of the most negative value, the choice between rd and 31 for the register call, and the wrap at the top of the address space.

// File: rtl/flow_pkg.sv
package flow_pkg;

    localparam int INSN_W   = 32;
    localparam int OPC_W    = 6;
    localparam int IMM_W    = 16;
    localparam int REGION_W = 26;

    localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_JUMP    = 6'b000010;
    localparam logic [OPC_W-1:0] OPC_CALL    = 6'b000011;
    localparam logic [OPC_W-1:0] OPC_BR_EQ   = 6'b000100;
    localparam logic [OPC_W-1:0] OPC_BR_NE   = 6'b000101;
    localparam logic [OPC_W-1:0] OPC_BR_LEZ  = 6'b000110;
    localparam logic [OPC_W-1:0] OPC_BR_GTZ  = 6'b000111;

    localparam logic [5:0] FN_JREG  = 6'b001000;
    localparam logic [5:0] FN_JLREG = 6'b001001;

    typedef enum logic [1:0] {
        NXT_SEQ,
        NXT_BRANCH,
        NXT_REGION,
        NXT_REG
    } nxt_src_e;

    typedef enum logic [2:0] {
        CMP_NONE,
        CMP_EQ,
        CMP_NE,
        CMP_LEZ,
        CMP_GTZ
    } cmp_kind_e;

    typedef struct packed {
        nxt_src_e  src;
        cmp_kind_e cmp;
        logic      link;
        logic      link_from_rd;
    } ctl_t;

endpackage

// File: rtl/flow_decode.sv
module flow_decode
    import flow_pkg::*;
(
    input  logic [INSN_W-1:0] instr,
    output ctl_t              ctl
);
    logic [OPC_W-1:0] opc;
    logic [5:0]       fn;
    ctl_t             ctl_d;

    assign opc = instr[31:26];
    assign fn  = instr[5:0];

    always_comb begin
        ctl_d = '{src: NXT_SEQ, cmp: CMP_NONE, link: 1'b0, link_from_rd: 1'b0};
        unique case (opc)
            OPC_JUMP: ctl_d.src = NXT_REGION;
            OPC_CALL: begin
                ctl_d.src  = NXT_REGION;
                ctl_d.link = 1'b1;
            end
            OPC_BR_EQ: begin
                ctl_d.src = NXT_BRANCH;
                ctl_d.cmp = CMP_EQ;
            end
            OPC_BR_NE: begin
                ctl_d.src = NXT_BRANCH;
                ctl_d.cmp = CMP_NE;
            end
            OPC_BR_LEZ: begin
                ctl_d.src = NXT_BRANCH;
                ctl_d.cmp = CMP_LEZ;
            end
            OPC_BR_GTZ: begin
                ctl_d.src = NXT_BRANCH;
                ctl_d.cmp = CMP_GTZ;
            end
            OPC_SPECIAL: begin
                if (fn == FN_JREG) begin
                    ctl_d.src = NXT_REG;
                end else if (fn == FN_JLREG) begin
                    ctl_d.src          = NXT_REG;
                    ctl_d.link         = 1'b1;
                    ctl_d.link_from_rd = 1'b1;
                end
            end
            default: ;
        endcase
    end

    assign ctl = ctl_d;

    // R2 / R5 / R7: at most one transfer source selected per instruction
    always_comb begin
        p_one_source_r2: assert ($onehot0({ctl.cmp != CMP_NONE,
                                           ctl.src == NXT_REGION,
                                           ctl.src == NXT_REG}))
            else $error("decoder selected several transfer sources");
        // R6 / R8: links come only with jumps
        p_link_on_jump_r8: assert (!ctl.link || ctl.src == NXT_REGION || ctl.src == NXT_REG)
            else $error("link requested on a non-jump");
    end

endmodule

// File: rtl/flow_cond.sv
module flow_cond
    import flow_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  cmp_kind_e        kind,
    input  logic [XLEN-1:0]  a,
    input  logic [XLEN-1:0]  b,
    output logic             hit
);
    logic a_zero;
    logic a_neg;
    logic hit_d;

    assign a_zero = (a == '0);
    assign a_neg  = a[XLEN-1];

    always_comb begin
        hit_d = 1'b0;
        unique case (kind)
            CMP_EQ:  hit_d = (a == b);
            CMP_NE:  hit_d = (a != b);
            CMP_LEZ: hit_d = a_neg | a_zero;
            CMP_GTZ: hit_d = !a_neg && !a_zero;
            default: hit_d = 1'b0;
        endcase
    end

    assign hit = hit_d;

    // R9: an unselected comparison never reports a hit
    always_comb begin
        p_idle_no_hit_r9: assert (kind != CMP_NONE || !hit)
            else $error("comparison hit without a branch");
        // R4: a zero operand always counts as at-most-zero
        p_zero_lez_r4: assert (!(kind == CMP_LEZ && a_zero) || hit)
            else $error("zero operand not treated as at most zero");
    end

endmodule

// File: rtl/flow_target.sv
module flow_target
    import flow_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]   pc_plus4,
    input  logic [INSN_W-1:0] instr,
    input  logic [XLEN-1:0]   rs_val,
    input  nxt_src_e          src,
    input  logic              cond_hit,
    output logic [XLEN-1:0]   next_pc,
    output logic              taken
);
    localparam int HI_W   = XLEN - REGION_W - 2;
    localparam int SEXT_W = XLEN - IMM_W - 2;

    typedef struct packed {
        logic [XLEN-1:0] next_pc;
        logic            taken;
    } tgt_t;

    logic [XLEN-1:0] br_off;
    logic [XLEN-1:0] br_tgt;
    logic [XLEN-1:0] region_tgt;
    tgt_t            tgt_d;

    assign br_off     = {{SEXT_W{instr[IMM_W-1]}}, instr[IMM_W-1:0], 2'b00};
    assign br_tgt     = pc_plus4 + br_off;
    assign region_tgt = {pc_plus4[XLEN-1 -: HI_W], instr[REGION_W-1:0], 2'b00};

    always_comb begin
        tgt_d = '{next_pc: pc_plus4, taken: 1'b0};
        unique case (src)
            NXT_BRANCH: if (cond_hit) tgt_d = '{next_pc: br_tgt, taken: 1'b1};
            NXT_REGION: tgt_d = '{next_pc: region_tgt, taken: 1'b1};
            NXT_REG:    tgt_d = '{next_pc: rs_val, taken: 1'b1};
            default:    ;
        endcase
    end

    assign next_pc = tgt_d.next_pc;
    assign taken   = tgt_d.taken;

    always_comb begin
        // R1 / R10: no transfer means the sequential address
        p_seq_when_idle_r1: assert (taken || next_pc == pc_plus4)
            else $error("non-transfer left the sequential path");
        // R5: region targets keep the upper bits and are word aligned
        p_region_shape_r5: assert (src != NXT_REGION ||
                                   (next_pc[1:0] == 2'b00 &&
                                    next_pc[XLEN-1 -: HI_W] == pc_plus4[XLEN-1 -: HI_W]))
            else $error("region target malformed");
        // R10: sequential source never reports a transfer
        p_seq_not_taken_r10: assert (src != NXT_SEQ || !taken)
            else $error("sequential instruction flagged as taken");
    end

endmodule

// File: rtl/flow_next_pc.sv
module flow_next_pc
    import flow_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int RIDX_W   = 5,
    parameter int LINK_REG = 31
) (
    input  logic [XLEN-1:0]   pc_i,
    input  logic [INSN_W-1:0] instr_i,
    input  logic [XLEN-1:0]   rs_val_i,
    input  logic [XLEN-1:0]   rt_val_i,
    output logic [XLEN-1:0]   next_pc_o,
    output logic              taken_o,
    output logic              link_we_o,
    output logic [RIDX_W-1:0] link_idx_o,
    output logic [XLEN-1:0]   link_data_o
);
    localparam logic [RIDX_W-1:0] LINK_IDX = RIDX_W'(LINK_REG);

    typedef struct packed {
        logic              we;
        logic [RIDX_W-1:0] idx;
    } link_t;

    ctl_t              ctl;
    logic              cond_hit;
    logic [XLEN-1:0]   pc_plus4;
    logic [RIDX_W-1:0] rd_field;
    link_t             link_d;

    assign pc_plus4 = pc_i + XLEN'(4);
    assign rd_field = instr_i[15:11];

    flow_decode u_decode (
        .instr (instr_i),
        .ctl   (ctl)
    );

    flow_cond #(.XLEN(XLEN)) u_cond (
        .kind (ctl.cmp),
        .a    (rs_val_i),
        .b    (rt_val_i),
        .hit  (cond_hit)
    );

    flow_target #(.XLEN(XLEN)) u_target (
        .pc_plus4 (pc_plus4),
        .instr    (instr_i),
        .rs_val   (rs_val_i),
        .src      (ctl.src),
        .cond_hit (cond_hit),
        .next_pc  (next_pc_o),
        .taken    (taken_o)
    );

    always_comb begin
        link_d = '{we: 1'b0, idx: '0};
        if (ctl.link) begin
            if (ctl.link_from_rd && rd_field != '0) link_d.idx = rd_field;
            else                                    link_d.idx = LINK_IDX;
            link_d.we = (link_d.idx != '0);
            if (!link_d.we) link_d.idx = '0;
        end
    end

    assign link_we_o   = link_d.we;
    assign link_idx_o  = link_d.idx;
    assign link_data_o = pc_plus4;

    always_comb begin
        // R8: register 0 is never a link destination
        p_no_zero_dest_r8: assert (!link_we_o || link_idx_o != '0)
            else $error("link write to register 0");
        // R6 / R8: every link write comes with a transfer
        p_link_with_transfer_r6: assert (!link_we_o || taken_o)
            else $error("link write without a transfer");
        // R10: idle link index is zero
        p_idle_idx_zero_r10: assert (link_we_o || link_idx_o == '0)
            else $error("link index set without a write");
    end

endmodule

// File: tb/flow_next_pc_test.sv
module flow_next_pc_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_i = '0;
    logic [31:0] instr_i = '0;
    logic [31:0] rs_val_i = '0;
    logic [31:0] rt_val_i = '0;
    logic [31:0] next_pc_o;
    logic        taken_o;
    logic        link_we_o;
    logic [4:0]  link_idx_o;
    logic [31:0] link_data_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flow_next_pc uut (
        .pc_i        (pc_i),
        .instr_i     (instr_i),
        .rs_val_i    (rs_val_i),
        .rt_val_i    (rt_val_i),
        .next_pc_o   (next_pc_o),
        .taken_o     (taken_o),
        .link_we_o   (link_we_o),
        .link_idx_o  (link_idx_o),
        .link_data_o (link_data_o)
    );

    function automatic logic [31:0] mk_i(input logic [5:0] op, input logic [4:0] rs,
                                         input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] mk_j(input logic [5:0] op, input logic [25:0] fld);
        return {op, fld};
    endfunction

    function automatic logic [31:0] mk_r(input logic [4:0] rs, input logic [4:0] rd,
                                         input logic [5:0] fn);
        return {6'b000000, rs, 5'd0, rd, 5'd0, fn};
    endfunction

    task automatic cmp(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] pc, input logic [31:0] ins,
                         input logic [31:0] rs, input logic [31:0] rt);
        @(negedge clk);
        pc_i = pc; instr_i = ins; rs_val_i = rs; rt_val_i = rt;
        #2;
    endtask

    task automatic expect_out(input string req, input logic [31:0] npc, input logic tk,
                              input logic we, input logic [4:0] idx, input logic [31:0] data);
        cmp(req, "next_pc", next_pc_o, npc);
        cmp(req, "taken", {31'd0, taken_o}, {31'd0, tk});
        cmp(req, "link_we", {31'd0, link_we_o}, {31'd0, we});
        cmp(req, "link_idx", {27'd0, link_idx_o}, {27'd0, idx});
        cmp(req, "link_data", link_data_o, data);
    endtask

    task automatic t_idle;
        apply(32'h0, 32'h0, 32'h0, 32'h0);
        expect_out("R1", 32'h4, 1'b0, 1'b0, 5'd0, 32'h4);
    endtask

    task automatic t_sequential_r1;
        apply(32'h0040_0000, mk_i(6'b001000, 5'd3, 5'd4, 16'h0010), 32'h5, 32'h5);
        expect_out("R1", 32'h0040_0004, 1'b0, 1'b0, 5'd0, 32'h0040_0004);
        apply(32'h0000_1000, mk_i(6'b100011, 5'd1, 5'd2, 16'hFFFF), 32'h0, 32'h0);
        expect_out("R1", 32'h0000_1004, 1'b0, 1'b0, 5'd0, 32'h0000_1004);
    endtask

    task automatic t_equal_branches_r3;
        apply(32'h1000, mk_i(6'b000100, 5'd1, 5'd2, 16'h0003), 32'hABCD, 32'hABCD);
        expect_out("R3", 32'h1010, 1'b1, 1'b0, 5'd0, 32'h1004);
        apply(32'h1000, mk_i(6'b000100, 5'd1, 5'd2, 16'h0003), 32'hABCD, 32'hABCE);
        expect_out("R3", 32'h1004, 1'b0, 1'b0, 5'd0, 32'h1004);
        apply(32'h3000, mk_i(6'b000101, 5'd1, 5'd2, 16'h0010), 32'h1, 32'h2);
        expect_out("R3", 32'h3044, 1'b1, 1'b0, 5'd0, 32'h3004);
        apply(32'h3000, mk_i(6'b000101, 5'd1, 5'd2, 16'h0010), 32'h7, 32'h7);
        expect_out("R3", 32'h3004, 1'b0, 1'b0, 5'd0, 32'h3004);
    endtask

    task automatic t_offsets_r2;
        apply(32'h2000, mk_i(6'b000100, 5'd0, 5'd0, 16'hFFFF), 32'h0, 32'h0);
        expect_out("R2", 32'h2000, 1'b1, 1'b0, 5'd0, 32'h2004);
        apply(32'h0, mk_i(6'b000100, 5'd0, 5'd0, 16'h7FFF), 32'h0, 32'h0);
        expect_out("R2", 32'h0002_0000, 1'b1, 1'b0, 5'd0, 32'h4);
        apply(32'h0010_0000, mk_i(6'b000100, 5'd0, 5'd0, 16'h8000), 32'h0, 32'h0);
        expect_out("R2", 32'h000E_0004, 1'b1, 1'b0, 5'd0, 32'h0010_0004);
        apply(32'h0, mk_i(6'b000100, 5'd0, 5'd0, 16'h0000), 32'h9, 32'h9);
        expect_out("R2", 32'h4, 1'b1, 1'b0, 5'd0, 32'h4);
    endtask

    task automatic t_sign_branches_r4;
        apply(32'h400, mk_i(6'b000110, 5'd5, 5'd9, 16'h0002), 32'h0, 32'h1234);
        expect_out("R4", 32'h40C, 1'b1, 1'b0, 5'd0, 32'h404);
        apply(32'h400, mk_i(6'b000110, 5'd5, 5'd9, 16'h0002), 32'h8000_0000, 32'h0);
        expect_out("R4", 32'h40C, 1'b1, 1'b0, 5'd0, 32'h404);
        apply(32'h400, mk_i(6'b000110, 5'd5, 5'd9, 16'h0002), 32'h1, 32'hFFFF_FFFF);
        expect_out("R4", 32'h404, 1'b0, 1'b0, 5'd0, 32'h404);
        apply(32'h400, mk_i(6'b000111, 5'd5, 5'd9, 16'h0002), 32'h1, 32'h0);
        expect_out("R4", 32'h40C, 1'b1, 1'b0, 5'd0, 32'h404);
        apply(32'h400, mk_i(6'b000111, 5'd5, 5'd9, 16'h0002), 32'hFFFF_FFFF, 32'h5);
        expect_out("R4", 32'h404, 1'b0, 1'b0, 5'd0, 32'h404);
        apply(32'h400, mk_i(6'b000111, 5'd5, 5'd9, 16'h0002), 32'h0, 32'h5);
        expect_out("R4", 32'h404, 1'b0, 1'b0, 5'd0, 32'h404);
        apply(32'h400, mk_i(6'b000111, 5'd5, 5'd9, 16'h0002), 32'h7FFF_FFFF, 32'h0);
        expect_out("R4", 32'h40C, 1'b1, 1'b0, 5'd0, 32'h404);
    endtask

    task automatic t_region_r5_r6;
        apply(32'h9D00_0040, mk_j(6'b000010, 26'h340001F), 32'h0, 32'h0);
        expect_out("R5", 32'h9D00_007C, 1'b1, 1'b0, 5'd0, 32'h9D00_0044);
        apply(32'h9D00_0040, mk_j(6'b000011, 26'h340001F), 32'h0, 32'h0);
        expect_out("R6", 32'h9D00_007C, 1'b1, 1'b1, 5'd31, 32'h9D00_0044);
        apply(32'h1FFF_FFF8, mk_j(6'b000011, 26'h3FFFFFF), 32'h0, 32'h0);
        expect_out("R6", 32'h1FFF_FFFC, 1'b1, 1'b1, 5'd31, 32'h1FFF_FFFC);
    endtask

    task automatic t_register_jumps_r7_r8;
        apply(32'h0040_0010, mk_r(5'd4, 5'd0, 6'b001000), 32'h0040_0100, 32'h0);
        expect_out("R7", 32'h0040_0100, 1'b1, 1'b0, 5'd0, 32'h0040_0014);
        apply(32'h0040_0010, mk_r(5'd4, 5'd0, 6'b001001), 32'h0080_0000, 32'h0);
        expect_out("R8", 32'h0080_0000, 1'b1, 1'b1, 5'd31, 32'h0040_0014);
        apply(32'h0040_0020, mk_r(5'd4, 5'd7, 6'b001001), 32'h0000_0200, 32'h0);
        expect_out("R8", 32'h0000_0200, 1'b1, 1'b1, 5'd7, 32'h0040_0024);
    endtask

    task automatic t_other_special_r9;
        apply(32'h500, mk_r(5'd4, 5'd6, 6'b100000), 32'h0000_0800, 32'h1);
        expect_out("R9", 32'h504, 1'b0, 1'b0, 5'd0, 32'h504);
        apply(32'h500, mk_r(5'd4, 5'd6, 6'b001010), 32'h0000_0800, 32'h1);
        expect_out("R9", 32'h504, 1'b0, 1'b0, 5'd0, 32'h504);
    endtask

    task automatic t_wrap_r11;
        apply(32'hFFFF_FFFC, 32'h0, 32'h0, 32'h0);
        expect_out("R11", 32'h0, 1'b0, 1'b0, 5'd0, 32'h0);
        apply(32'hFFFF_FFFC, mk_j(6'b000010, 26'h0000010), 32'h0, 32'h0);
        expect_out("R11", 32'h40, 1'b1, 1'b0, 5'd0, 32'h0);
        apply(32'hFFFF_FFF0, mk_i(6'b000100, 5'd0, 5'd0, 16'h0008), 32'h0, 32'h0);
        expect_out("R11", 32'h14, 1'b1, 1'b0, 5'd0, 32'hFFFF_FFF4);
    endtask

    task automatic t_taken_flag_r10;
        apply(32'h600, mk_i(6'b000101, 5'd1, 5'd2, 16'h0004), 32'h3, 32'h3);
        cmp("R10", "taken", {31'd0, taken_o}, 32'd0);
        cmp("R10", "link_idx", {27'd0, link_idx_o}, 32'd0);
        apply(32'h600, mk_r(5'd1, 5'd9, 6'b001000), 32'h0000_0604, 32'h0);
        cmp("R10", "taken", {31'd0, taken_o}, 32'd1);
        cmp("R10", "link_idx", {27'd0, link_idx_o}, 32'd0);
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
            report();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        t_sequential_r1();
        t_offsets_r2();
        t_equal_branches_r3();
        t_sign_branches_r4();
        t_region_r5_r6();
        t_register_jumps_r7_r8();
        t_other_special_r9();
        t_taken_flag_r10();
        t_wrap_r11();
        report();
    end

endmodule